// File: doc/BRIEF.md
# Time Base and Event Tag Register Slave

This block is a 32-bit Wishbone classic slave that gives software a window onto a time base and four event time-tags. It decodes a 5-bit word address into 18 word registers. The first two registers are the seconds count and the coarse tick count of the time base. The other sixteen are time-tags for four events: a trigger, acquisition start, acquisition stop and acquisition end. Each tag is four words: metadata, seconds, coarse ticks and fine time.

The two time-base registers do not store what software writes. A full-word write to either one drives the written word onto a value output and raises a matching load strobe for one clock, so that the counter logic outside the block can take the value. A read of either one returns the live count that the counter logic presents on its input. The sixteen tag words are read-only views of hardware inputs. Every access is acknowledged one clock after it is requested, and the read data is registered so that it is valid in the acknowledge cycle.

Top module: `time_reg_slave`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and in the first cycle after it is released, `busAck`, `secLoad` and `tickLoad` are low, and `secOut`, `tickOut` and `busDatR` are zero.
- R2: `busAck` rises one clock after `busCyc` and `busStb` are both high, and stays high for exactly one cycle. If the request is held, the acknowledge cycles alternate with idle cycles, so each acknowledge ends one transfer.
- R3: A read of word address 0 returns `secIn`, and a read of word address 1 returns `tickIn`, as sampled in the request cycle. The data is on `busDatR` in the cycle where `busAck` is high.
- R4: A read of word address 2+k (k = 0..15) returns `tagWords[32k+31:32k]`. The words are grouped as trigger 2–5, acquisition start 6–9, acquisition stop 10–13 and acquisition end 14–17. Inside each group the order is metadata, seconds, coarse, fine.
- R5: A read of an unmapped word address (0x12–0x1F) returns zero and is still acknowledged.
- R6: A write to address 0 with `busSel` = 4'hF puts the written word on `secOut` and pulses `secLoad` high for exactly one clock. The pulse falls in the acknowledge cycle. `secOut` keeps that value until the next such write.
- R7: A write to address 1 with `busSel` = 4'hF puts the written word on `tickOut` and pulses `tickLoad` high for exactly one clock. The pulse falls in the acknowledge cycle. `tickOut` keeps that value until the next such write.
- R8: Writes to read-only addresses (2–17) and to unmapped addresses (18–31) are acknowledged. They raise no load strobe and leave `secOut` and `tickOut` unchanged.
- R9: A write to address 0 or 1 with any `busSel` other than 4'hF is acknowledged. It raises no load strobe and changes no value output.
- R10: After a write to address 0 or 1, a read of that address returns the live input, not the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAdr | input | 5 | Word address |
| busDatW | input | 32 | Write data |
| busDatR | output | 32 | Registered read data |
| busCyc | input | 1 | Bus cycle in progress |
| busSel | input | 4 | Byte select; only 4'hF writes |
| busStb | input | 1 | Transfer strobe |
| busWe | input | 1 | Write enable |
| busAck | output | 1 | Transfer acknowledge |
| secOut | output | 32 | Seconds value written by software |
| secIn | input | 32 | Live seconds count |
| secLoad | output | 1 | One-clock seconds load strobe |
| tickOut | output | 32 | Coarse tick value written by software |
| tickIn | input | 32 | Live coarse tick count |
| tickLoad | output | 1 | One-clock coarse tick load strobe |
| tagWords | input | 512 | Sixteen tag words, word k at bits 32k+31:32k |

## Verification
A write to a time-base register lands in the same cycle as its acknowledge, because the load strobe and `busAck` are both registered from the same accepted request. The bench provokes this in two ways. It sends single writes, and it holds `busStb` high with `busWe` set, so that several writes run back to back. In every sampled cycle it checks that the strobe matches the acknowledge and that the value output already carries the written word. A read straight after each write checks that the live input comes back rather than the stored value.

// File: rtl/time_reg_pkg.sv
package time_reg_pkg;
  localparam int DATA_W    = 32;
  localparam int ADR_W     = 5;
  localparam int NUM_TAGS  = 4;
  localparam int TAG_WORDS = 4;
  localparam int NUM_TAG_REGS = NUM_TAGS * TAG_WORDS;
  localparam int FIRST_TAG    = 2;
  localparam int LAST_MAPPED  = FIRST_TAG + NUM_TAG_REGS - 1;

  typedef struct packed {
    logic rdEn;
    logic wrSec;
    logic wrTick;
  } ctrlStrobes_t;
endpackage

// File: rtl/time_reg_ctrl.sv
module time_reg_ctrl
  import time_reg_pkg::*;
#(
  parameter int AW = ADR_W,
  parameter int SW = DATA_W / 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cyc,
  input  logic          stb,
  input  logic          we,
  input  logic [SW-1:0] sel,
  input  logic [AW-1:0] adr,
  output logic          ack,
  output ctrlStrobes_t  strobes
);
  logic accept;
  logic fullWord;

  assign accept   = cyc & stb & ~ack;
  assign fullWord = &sel;

  always_comb begin
    strobes.rdEn   = accept & ~we;
    strobes.wrSec  = accept & we & fullWord & (adr == AW'(0));
    strobes.wrTick = accept & we & fullWord & (adr == AW'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ack <= 1'b0;
    else       ack <= accept;
  end
endmodule

// File: rtl/time_reg_dp.sv
module time_reg_dp
  import time_reg_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADR_W,
  parameter int NTAGW = NUM_TAG_REGS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [AW-1:0]     adr,
  input  logic [DW-1:0]     datW,
  input  logic [DW-1:0]     secIn,
  input  logic [DW-1:0]     tickIn,
  input  logic [NTAGW*DW-1:0] tagWords,
  output logic [DW-1:0]     datR,
  output logic [DW-1:0]     secOut,
  output logic              secLoad,
  output logic [DW-1:0]     tickOut,
  output logic              tickLoad
);
  logic [DW-1:0] rdMux;

  always_comb begin
    rdMux = '0;
    if (adr == AW'(0)) rdMux = secIn;
    if (adr == AW'(1)) rdMux = tickIn;
    for (int i = 0; i < NTAGW; i++) begin
      if (adr == AW'(FIRST_TAG + i)) rdMux = tagWords[DW*i +: DW];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      datR     <= '0;
      secOut   <= '0;
      tickOut  <= '0;
      secLoad  <= 1'b0;
      tickLoad <= 1'b0;
    end else begin
      secLoad  <= strobes.wrSec;
      tickLoad <= strobes.wrTick;
      if (strobes.wrSec)  secOut  <= datW;
      if (strobes.wrTick) tickOut <= datW;
      if (strobes.rdEn)   datR    <= rdMux;
    end
  end
endmodule

// File: rtl/time_reg_slave.sv
module time_reg_slave
  import time_reg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADR_W-1:0]             busAdr,
  input  logic [DATA_W-1:0]            busDatW,
  output logic [DATA_W-1:0]            busDatR,
  input  logic                         busCyc,
  input  logic [DATA_W/8-1:0]          busSel,
  input  logic                         busStb,
  input  logic                         busWe,
  output logic                         busAck,
  output logic [DATA_W-1:0]            secOut,
  input  logic [DATA_W-1:0]            secIn,
  output logic                         secLoad,
  output logic [DATA_W-1:0]            tickOut,
  input  logic [DATA_W-1:0]            tickIn,
  output logic                         tickLoad,
  input  logic [NUM_TAG_REGS*DATA_W-1:0] tagWords
);
  ctrlStrobes_t strobes;

  time_reg_ctrl #(.AW(ADR_W), .SW(DATA_W/8)) u_ctrl (
    .clk(clk), .rstN(rstN), .cyc(busCyc), .stb(busStb), .we(busWe),
    .sel(busSel), .adr(busAdr), .ack(busAck), .strobes(strobes)
  );

  time_reg_dp #(.DW(DATA_W), .AW(ADR_W), .NTAGW(NUM_TAG_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .adr(busAdr),
    .datW(busDatW), .secIn(secIn), .tickIn(tickIn), .tagWords(tagWords),
    .datR(busDatR), .secOut(secOut), .secLoad(secLoad),
    .tickOut(tickOut), .tickLoad(tickLoad)
  );
endmodule

// File: rtl/time_reg_chk.sv
module time_reg_chk
  import time_reg_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [ADR_W-1:0]   busAdr,
  input logic [DATA_W-1:0]  busDatW,
  input logic [DATA_W-1:0]  busDatR,
  input logic               busCyc,
  input logic [DATA_W/8-1:0] busSel,
  input logic               busStb,
  input logic               busWe,
  input logic               busAck,
  input logic [DATA_W-1:0]  secOut,
  input logic               secLoad,
  input logic [DATA_W-1:0]  tickOut,
  input logic               tickLoad
);
  // R2: acknowledge only after a request, and never two in a row
  p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAck |-> $past(busCyc && busStb));
  p_ack_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAck |=> !busAck);
  p_req_gets_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busCyc && busStb && !busAck) |=> busAck);
  // R6 / R7: load pulses are one clock, ride on the acknowledge, carry write data
  p_sec_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    secLoad |-> (busAck && secOut == $past(busDatW)));
  p_tick_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    tickLoad |-> (busAck && tickOut == $past(busDatW)));
  p_sec_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !secLoad |-> $stable(secOut));
  // R8 / R9: no strobe without a full-word write to its own address
  p_sec_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    secLoad |-> $past(busWe && busAdr == '0 && busSel == '1));
  p_one_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({secLoad, tickLoad}));
  // R5: unmapped reads give zero
  p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busAck && $past(!busWe && busAdr > ADR_W'(LAST_MAPPED))) |-> busDatR == '0);
endmodule

bind time_reg_slave time_reg_chk u_chk (
  .clk(clk), .rstN(rstN), .busAdr(busAdr), .busDatW(busDatW),
  .busDatR(busDatR), .busCyc(busCyc), .busSel(busSel), .busStb(busStb),
  .busWe(busWe), .busAck(busAck), .secOut(secOut), .secLoad(secLoad),
  .tickOut(tickOut), .tickLoad(tickLoad)
);

// File: tb/time_reg_slave_tb.sv
module time_reg_slave_tb;
  import time_reg_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADR_W-1:0] busAdr = '0;
  logic [31:0] busDatW = '0;
  logic [31:0] busDatR;
  logic busCyc = 1'b0, busStb = 1'b0, busWe = 1'b0, busAck;
  logic [3:0] busSel = 4'hF;
  logic [31:0] secOut, tickOut;
  logic [31:0] secIn = 32'h0000_1000, tickIn = 32'h0200_0000;
  logic secLoad, tickLoad;
  logic [NUM_TAG_REGS*32-1:0] tagWords;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  time_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .busAdr(busAdr), .busDatW(busDatW),
    .busDatR(busDatR), .busCyc(busCyc), .busSel(busSel), .busStb(busStb),
    .busWe(busWe), .busAck(busAck), .secOut(secOut), .secIn(secIn),
    .secLoad(secLoad), .tickOut(tickOut), .tickIn(tickIn),
    .tickLoad(tickLoad), .tagWords(tagWords)
  );

  function automatic logic [31:0] tagPat(int k);
    return 32'hC000_0000 + 32'(k) * 32'h0101_0011;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One transfer; returns read data and load flags seen in the ack cycle
  task automatic xfer(input logic [4:0] a, input logic w, input logic [31:0] d,
                      input logic [3:0] s, output logic [31:0] rd,
                      output logic sL, output logic tL, input string req);
    @(negedge clk);
    busAdr = a; busWe = w; busDatW = d; busSel = s; busCyc = 1'b1; busStb = 1'b1;
    @(negedge clk);
    chk({req, " ack"}, 32'(busAck), 32'd1);
    rd = busDatR; sL = secLoad; tL = tickLoad;
    busCyc = 1'b0; busStb = 1'b0; busWe = 1'b0;
    @(negedge clk);
    chk({req, " ack low after"}, 32'(busAck), 32'd0);
    chk({req, " loads low after"}, {30'd0, secLoad, tickLoad}, 32'd0);
  endtask

  initial begin
    for (int k = 0; k < NUM_TAG_REGS; k++) tagWords[32*k +: 32] = tagPat(k);
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic sL, tL;
    logic [31:0] expSec, expTick;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ack", 32'(busAck), 0);
    chk("R1 loads", {30'd0, secLoad, tickLoad}, 0);
    chk("R1 secOut", secOut, 0);
    chk("R1 tickOut", tickOut, 0);
    chk("R1 datR", busDatR, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {31'd0, busAck} | secOut | tickOut | busDatR, 0);

    // R3 R4 R5: sweep every read address
    for (int a = 0; a < 32; a++) begin
      logic [31:0] exp;
      secIn = 32'h0000_1000 + 32'(a); tickIn = 32'h0200_0000 + 32'(a * 7);
      exp = (a == 0) ? secIn : (a == 1) ? tickIn :
            (a <= LAST_MAPPED) ? tagPat(a - FIRST_TAG) : 32'd0;
      xfer(5'(a), 1'b0, 32'hFFFF_FFFF, 4'hF, rd, sL, tL,
           (a < 2) ? "R3 read" : (a <= LAST_MAPPED) ? "R4 read" : "R5 read");
      chk((a < 2) ? "R3 data" : (a <= LAST_MAPPED) ? "R4 data" : "R5 data", rd, exp);
      chk("R8 no load on read", {30'd0, sL, tL}, 0);
    end

    // R6 R7 R10: full-word writes then live readback
    expSec = 32'h0;
    expTick = 32'h0;
    for (int n = 0; n < 4; n++) begin
      expSec = 32'h5EC0_0000 + 32'(n * 3);
      xfer(5'd0, 1'b1, expSec, 4'hF, rd, sL, tL, "R6 write");
      chk("R6 secLoad in ack cycle", {30'd0, sL, tL}, 32'd2);
      chk("R6 secOut", secOut, expSec);
      secIn = 32'h0000_2000 + 32'(n);
      xfer(5'd0, 1'b0, 32'h0, 4'hF, rd, sL, tL, "R10 read");
      chk("R10 live seconds", rd, secIn);
      chk("R6 secOut held", secOut, expSec);
      expTick = 32'h07A1_0000 + 32'(n * 5);
      xfer(5'd1, 1'b1, expTick, 4'hF, rd, sL, tL, "R7 write");
      chk("R7 tickLoad in ack cycle", {30'd0, sL, tL}, 32'd1);
      chk("R7 tickOut", tickOut, expTick);
      tickIn = 32'h0000_3000 + 32'(n);
      xfer(5'd1, 1'b0, 32'h0, 4'hF, rd, sL, tL, "R10 read");
      chk("R10 live ticks", rd, tickIn);
    end

    // R8: writes to read-only and unmapped addresses
    for (int a = 2; a < 32; a++) begin
      xfer(5'(a), 1'b1, 32'hDEAD_0000 + 32'(a), 4'hF, rd, sL, tL, "R8 write");
      chk("R8 no load", {30'd0, sL, tL}, 0);
      chk("R8 secOut unchanged", secOut, expSec);
      chk("R8 tickOut unchanged", tickOut, expTick);
    end
    // R8: tags still read their inputs
    xfer(5'd5, 1'b0, 32'h0, 4'hF, rd, sL, tL, "R8 read");
    chk("R8 tag intact", rd, tagPat(3));

    // R9: partial byte selects ignored
    for (int s = 0; s < 15; s++) begin
      xfer(5'(s & 1), 1'b1, 32'hBAD0_0000 + 32'(s), 4'(s), rd, sL, tL, "R9 write");
      chk("R9 no load", {30'd0, sL, tL}, 0);
      chk("R9 secOut", secOut, expSec);
      chk("R9 tickOut", tickOut, expTick);
    end

    // R2 R6: held request, back-to-back writes; strobe must ride on ack
    @(negedge clk);
    busAdr = 5'd0; busWe = 1'b1; busSel = 4'hF; busDatW = 32'h0ABC_0001;
    busCyc = 1'b1; busStb = 1'b1;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R2 held ack pattern", 32'(busAck), (c % 2 == 0) ? 32'd1 : 32'd0);
      chk("R6 load equals ack", 32'(secLoad), 32'(busAck));
      if (busAck) chk("R6 held value", secOut, busDatW);
      busDatW = busDatW + 32'd1;
    end
    busCyc = 1'b0; busStb = 1'b0; busWe = 1'b0;
    @(negedge clk);
    // R2: stb without cyc is not a request
    busStb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 no ack without cyc", 32'(busAck), 0);
    busStb = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule